// File: doc/BRIEF.md
# Banked Register Move Unit

This block is a compact execution slice for an 8-bit controller core. It runs two single-word instructions. The first loads an 8-bit immediate into the working register (W). The second copies W into the on-chip banked data memory. Any other 16-bit word is treated as a no-operation.

Each accepted instruction passes through four internal phases, one clock each: decode, operand read, process and write. The target address of a store comes from one of three sources. It can be the low-memory or high-memory half of a fixed shared window, a 256-byte bank picked by a bank-select input, or an offset added to an index base. The index form applies only when the extended mode input is set and the offset is 5Fh or lower.

The unit owns its data memory of 16 banks of 256 bytes, reached through a 12-bit address. W and a registered commit record of each store (strobe, address, data) are brought out. The previous content of the stored-to location, read during the operand phase, is also brought out. Instruction fetch, the program counter, flags and interrupts are handled elsewhere.

Top module: `bank_move_unit`

## Requirements
- R1: After synchronous reset, W reads 00h, the ready output is 1 and the store strobe is 0.
- R2: The word 0Eh:k (upper byte 0Eh, lower byte k) loads k into W. The new value is visible one clock after the fourth phase, and no store strobe is raised.
- R3: A word whose upper seven bits are 0110111 (upper byte 6Eh or 6Fh) stores W to the effective address and leaves W unchanged. The store strobe is high for exactly one clock after the fourth phase, with address and data valid in that clock.
- R4: For a store with bit 8 set, the effective address is {bank-select bits 3:0, low byte}. The upper four bank-select bits are ignored.
- R5: For a store with bit 8 clear and no indexing, a low byte of 00h-5Fh addresses 000h-05Fh, and a low byte of 60h-FFh addresses F60h-FFFh.
- R6: For a store with bit 8 clear, extended mode set and a low byte at or below 5Fh, the effective address is (index base + low byte) modulo 4096. Low bytes above 5Fh still use the high window.
- R7: An instruction is taken when valid and ready are both high at a clock edge. Ready is low for the three clocks after acceptance and high again in the fourth-phase clock. A word presented while ready is low is ignored.
- R8: Any other upper byte takes the same four-phase cycle and changes neither W nor memory, and it raises no store strobe.
- R9: A store reads its target location in the operand phase. The old-value output shows the byte held there before the write, from the store's completion until the next store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid_i | input | 1 | Instruction word present |
| instr_i | input | 16 | Instruction word |
| instr_ready_o | output | 1 | Unit can take a word this clock |
| bank_sel_i | input | 8 | Bank select; low 4 bits used |
| ext_en_i | input | 1 | Extended (indexed) mode enable |
| index_base_i | input | 12 | Base address for indexed offsets |
| wreg_o | output | 8 | Working register |
| wr_en_o | output | 1 | One-clock store commit strobe |
| wr_addr_o | output | 12 | Effective address of the committed store |
| wr_data_o | output | 8 | Byte written by the committed store |
| rd_old_o | output | 8 | Previous content of the last stored-to location |

## Verification
The address assertions rebuild the effective address from the bank-select, mode and index-base inputs at the moment the store commits. They therefore assume these inputs stay constant from acceptance until the fourth phase completes. The bench changes them only while the unit is idle, before the next word is offered. The checks on the old-value output assume the memory has been written at that location first. The bench compares that output only for addresses its own model has already stored to.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned INSTR_W = 16;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_LIT   = 2'd1,
    OP_STORE = 2'd2
  } op_e;

  localparam logic [7:0] LIT_OPC   = 8'h0E;
  localparam logic [6:0] STORE_OPC = 7'b0110111;

  function automatic op_e decode_op(input logic [INSTR_W-1:0] w);
    if (w[15:8] == LIT_OPC)        return OP_LIT;
    else if (w[15:9] == STORE_OPC) return OP_STORE;
    else                           return OP_NOP;
  endfunction
endpackage

// File: rtl/bmu_seq.sv
module bmu_seq #(
  parameter int unsigned PHASES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              accept_o,
  output logic [PHASES-1:0] ph_end_o
);
  localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic          busy_q;
  logic [PW-1:0] ph_q;

  assign ready_o  = !busy_q || (ph_q == LAST);
  assign accept_o = valid_i && ready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      ph_q   <= '0;
    end else if (busy_q) begin
      if (ph_q == LAST) begin
        busy_q <= 1'b0;
        ph_q   <= '0;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < PHASES; i++) begin : g_end
    assign ph_end_o[i] = busy_q && (ph_q == PW'(i));
  end
endmodule

// File: rtl/bmu_agen.sv
module bmu_agen #(
  parameter int unsigned BANK_W  = 4,
  parameter int unsigned OFF_W   = 8,
  parameter logic [7:0]  SPLIT   = 8'h5F,
  localparam int unsigned ADDR_W = BANK_W + OFF_W
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic              banked_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ext_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] ea_o
);
  logic low_half;
  assign low_half = (off_i <= OFF_W'(SPLIT));

  always_comb begin
    if (banked_i)
      ea_o = {bank_i, off_i};
    else if (ext_i && low_half)
      ea_o = base_i + {{BANK_W{1'b0}}, off_i};
    else if (low_half)
      ea_o = {{BANK_W{1'b0}}, off_i};
    else
      ea_o = {{BANK_W{1'b1}}, off_i};
  end
endmodule

// File: rtl/bmu_ram.sv
module bmu_ram #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/bank_move_unit.sv
module bank_move_unit
  import bmu_pkg::*;
#(
  parameter int unsigned BANK_W = 4,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned BSR_W  = 8,
  parameter int unsigned PHASES = 4,
  parameter logic [7:0]  SPLIT  = 8'h5F,
  localparam int unsigned ADDR_W = BANK_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               instr_ready_o,
  input  logic [BSR_W-1:0]   bank_sel_i,
  input  logic               ext_en_i,
  input  logic [ADDR_W-1:0]  index_base_i,
  output logic [DATA_W-1:0]  wreg_o,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic [DATA_W-1:0]  rd_old_o
);
  localparam int unsigned P_DEC  = 0;
  localparam int unsigned P_READ = 1;
  localparam int unsigned P_PROC = 2;
  localparam int unsigned P_WR   = PHASES - 1;

  logic              accept;
  logic [PHASES-1:0] ph_end;
  logic [INSTR_W-1:0] ir_q;
  op_e               op_q;
  logic [ADDR_W-1:0] ea_d, ea_q;
  logic [DATA_W-1:0] operand_q, result_q, wreg_q, ram_rdata, old_q;
  logic              wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;
  logic              ram_we, ram_re;
  logic              unused_bsr_hi;

  assign unused_bsr_hi = ^bank_sel_i[BSR_W-1:BANK_W];

  bmu_seq #(.PHASES(PHASES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .valid_i  (instr_valid_i),
    .ready_o  (instr_ready_o),
    .accept_o (accept),
    .ph_end_o (ph_end)
  );

  bmu_agen #(.BANK_W(BANK_W), .OFF_W(OFF_W), .SPLIT(SPLIT)) u_agen (
    .off_i    (ir_q[OFF_W-1:0]),
    .banked_i (ir_q[8]),
    .bank_i   (bank_sel_i[BANK_W-1:0]),
    .ext_i    (ext_en_i),
    .base_i   (index_base_i),
    .ea_o     (ea_d)
  );

  assign ram_re = ph_end[P_READ] && (op_q == OP_STORE);
  assign ram_we = ph_end[P_WR]   && (op_q == OP_STORE);

  bmu_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk     (clk),
    .we_i    (ram_we),
    .waddr_i (ea_q),
    .wdata_i (result_q),
    .re_i    (ram_re),
    .raddr_i (ea_q),
    .rdata_o (ram_rdata)
  );

  // capture and decode
  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q <= '0;
      op_q <= OP_NOP;
      ea_q <= '0;
    end else begin
      if (accept) ir_q <= instr_i;
      if (ph_end[P_DEC]) begin
        op_q <= decode_op(ir_q);
        ea_q <= ea_d;
      end
    end
  end

  // operand fetch and processing
  always_ff @(posedge clk) begin
    if (rst) begin
      operand_q <= '0;
      result_q  <= '0;
      old_q     <= '0;
    end else begin
      if (ph_end[P_READ])
        operand_q <= (op_q == OP_LIT) ? ir_q[DATA_W-1:0] : wreg_q;
      if (ph_end[P_PROC]) begin
        result_q <= operand_q;
        if (op_q == OP_STORE) old_q <= ram_rdata;
      end
    end
  end

  // destination write
  always_ff @(posedge clk) begin
    if (rst) begin
      wreg_q    <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= ram_we;
      if (ph_end[P_WR] && (op_q == OP_LIT)) wreg_q <= result_q;
      if (ram_we) begin
        wr_addr_q <= ea_q;
        wr_data_q <= result_q;
      end
    end
  end

  assign wreg_o    = wreg_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign rd_old_o  = old_q;
endmodule

// File: rtl/bank_move_unit_chk.sv
module bank_move_unit_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BSR_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid_i,
  input logic [15:0]       instr_i,
  input logic              instr_ready_o,
  input logic [BSR_W-1:0]  bank_sel_i,
  input logic              ext_en_i,
  input logic [ADDR_W-1:0] index_base_i,
  input logic [7:0]        wreg_o,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o
);
  logic [15:0] ir_c;
  logic [2:0]  low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_c    <= '0;
      low_cnt <= '0;
    end else begin
      if (instr_valid_i && instr_ready_o) ir_c <= instr_i;
      if (!instr_ready_o) low_cnt <= (low_cnt == 3'd7) ? low_cnt : low_cnt + 3'd1;
      else                low_cnt <= '0;
    end
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> !wr_en_o);

  a_r3_w_kept: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (wreg_o == $past(wreg_o)));

  a_r8_store_only: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (ir_c[15:9] == 7'b0110111));

  a_r7_busy_after_take: assert property (@(posedge clk) disable iff (rst)
    (instr_valid_i && instr_ready_o) |=> !instr_ready_o);

  a_r7_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= 3'd3);

  a_r4_banked_addr: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && ir_c[8]) |-> (wr_addr_o == {bank_sel_i[3:0], ir_c[7:0]}));

  a_r5_window_addr: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && !ir_c[8] && (!ext_en_i || ir_c[7:0] > 8'h5F)) |->
      (wr_addr_o == ((ir_c[7:0] > 8'h5F) ? {4'hF, ir_c[7:0]} : {4'h0, ir_c[7:0]})));

  a_r6_indexed_addr: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && !ir_c[8] && ext_en_i && ir_c[7:0] <= 8'h5F) |->
      (wr_addr_o == ADDR_W'(index_base_i + ADDR_W'(ir_c[7:0]))));
endmodule

bind bank_move_unit bank_move_unit_chk #(.ADDR_W(ADDR_W), .BSR_W(BSR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .instr_valid_i (instr_valid_i),
  .instr_i       (instr_i),
  .instr_ready_o (instr_ready_o),
  .bank_sel_i    (bank_sel_i),
  .ext_en_i      (ext_en_i),
  .index_base_i  (index_base_i),
  .wreg_o        (wreg_o),
  .wr_en_o       (wr_en_o),
  .wr_addr_o     (wr_addr_o)
);

// File: tb/bank_move_unit_bench.sv
module bank_move_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [15:0] instr = '0;
  logic        ready;
  logic [7:0]  bank_sel = '0;
  logic        ext_en = 1'b0;
  logic [11:0] base = '0;
  logic [7:0]  wreg;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_old;

  int errors = 0;
  int checks = 0;
  logic [7:0] w_exp = 8'h00;
  logic [7:0] ref_mem [4096];
  bit         ref_ok  [4096];

  always #2.5 clk = ~clk;

  bank_move_unit u_bank_move_unit (
    .clk(clk), .rst(rst), .instr_valid_i(valid), .instr_i(instr),
    .instr_ready_o(ready), .bank_sel_i(bank_sel), .ext_en_i(ext_en),
    .index_base_i(base), .wreg_o(wreg), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_old_o(rd_old)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // offer a word, wait for acceptance, then sit at the negedge after the fourth phase
  task automatic issue(input logic [15:0] w);
    @(negedge clk);
    while (!ready) @(negedge clk);
    valid = 1'b1;
    instr = w;
    @(negedge clk);
    valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_w(input logic [7:0] k);
    issue({8'h0E, k});
    w_exp = k;
    check("R2 load", wreg, k);
  endtask

  task automatic store(input string req, input bit a, input logic [7:0] f,
                       input logic [7:0] bs, input bit ext, input logic [11:0] b);
    logic [11:0] ea;
    bank_sel = bs; ext_en = ext; base = b;
    if (a)                    ea = {bs[3:0], f};
    else if (ext && f <= 8'h5F) ea = b + {4'h0, f};
    else if (f <= 8'h5F)      ea = {4'h0, f};
    else                      ea = {4'hF, f};
    issue({7'b0110111, a, f});
    check("R3 strobe", wr_en, 1'b1);
    check(req, wr_addr, ea);
    check("R3 data", wr_data, w_exp);
    check("R3 W kept", wreg, w_exp);
    if (ref_ok[ea]) check("R9 old value", rd_old, ref_mem[ea]);
    ref_mem[ea] = w_exp;
    ref_ok[ea]  = 1'b1;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 W", wreg, 8'h00);
    check("R1 ready", ready, 1'b1);
    check("R1 strobe", wr_en, 1'b0);

    // R2: every literal value
    for (int k = 0; k < 256; k++) begin
      load_w(8'(k));
      check("R2 no strobe", wr_en, 1'b0);
    end

    // R5: shared window, all offsets
    for (int f = 0; f < 256; f++) begin
      load_w(8'(f ^ 8'hA5));
      store("R5 window addr", 1'b0, 8'(f), 8'h00, 1'b0, 12'h000);
    end
    @(negedge clk);
    check("R3 pulse width", wr_en, 1'b0);

    // R6: indexed with wraparound base, then a mid base
    for (int f = 0; f < 256; f++) begin
      load_w(8'(f + 3));
      store("R6 indexed addr", 1'b0, 8'(f), 8'h00, 1'b1, 12'hFF0);
    end
    for (int f = 0; f < 96; f += 7) begin
      load_w(8'(f * 5));
      store("R6 indexed addr", 1'b0, 8'(f), 8'h00, 1'b1, 12'h7A3);
    end

    // R4: every bank, upper select bits set
    for (int b = 0; b < 16; b++) begin
      load_w(8'(b * 13 + 1));
      store("R4 banked addr", 1'b1, 8'(b * 17), 8'(8'hF0 | b), 1'b0, 12'h000);
      store("R4 banked addr", 1'b1, 8'(255 - b), 8'(8'h50 | b), 1'b1, 12'h123);
    end

    // R9: rewrite the window to see old contents
    for (int f = 0; f < 256; f += 3) begin
      load_w(8'(~f));
      store("R9 rewrite addr", 1'b0, 8'(f), 8'h00, 1'b0, 12'h000);
    end

    // R8: every other upper byte is a no-op
    load_w(8'h77);
    for (int h = 0; h < 256; h++) begin
      if (h == 8'h0E || h == 8'h6E || h == 8'h6F) continue;
      issue({8'(h), 8'h5A});
      check("R8 W unchanged", wreg, 8'h77);
      check("R8 no strobe", wr_en, 1'b0);
    end

    // R7: ready timing and hold-off of words offered while busy
    @(negedge clk);
    valid = 1'b1;
    instr = 16'h0E11;
    @(negedge clk);
    check("R7 ready low p1", ready, 1'b0);
    instr = 16'h0EAA;
    @(negedge clk);
    check("R7 ready low p2", ready, 1'b0);
    @(negedge clk);
    check("R7 ready low p3", ready, 1'b0);
    valid = 1'b0;
    @(negedge clk);
    check("R7 ready in p4", ready, 1'b1);
    @(negedge clk);
    check("R7 first word done", wreg, 8'h11);
    repeat (6) @(negedge clk);
    check("R7 busy word ignored", wreg, 8'h11);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule